// File: doc/BRIEF.md
# Indirect Register Window Access Checker

This block judges every access that a core makes to the indirect register windows. There are three windows: one for the machine level, one for the supervisor level and one for the virtual-supervisor level. Each window holds one select register and six alias registers. For each access the block receives the CSR address, the current privilege level, the virtualization bit, two state-enable gate bits and two flags. The gate bits come from the machine and hypervisor state-enable registers. The flags say whether the current select value is implemented for the host and for the guest. From these inputs the block produces one verdict: grant, illegal-instruction exception, or virtual-instruction exception.

The block holds no register contents and routes no data. It only decides which outcome applies, in a fixed priority:

1. Privilege and machine-gate faults give an illegal-instruction exception.
2. Then the virtualization faults give a virtual-instruction exception.
3. Then an unimplemented select value on an alias gives an illegal-instruction exception.
4. Otherwise the access is granted.

The verdict is registered, so it appears one clock after the inputs are presented. An address outside the windows gives no verdict at all.

Top module: `ind_csr_guard`

## Requirements
- R1: While `rst` is high all three outputs are 0. Otherwise the outputs show the verdict for the inputs sampled at the previous rising clock edge.
- R2: The windows lie at base addresses 0x350 (machine), 0x150 (supervisor) and 0x250 (virtual supervisor). Each window covers base offsets 0–3 and 5–7. Offset 0 is the select register and the other offsets are aliases. Any other address, including base+4 and base+8, drives all three outputs to 0.
- R3: At most one output is high at a time. For an address inside a window, exactly one output is high.
- R4: An access to the machine window from any level other than M, whether virtualized or not, gives an illegal-instruction exception.
- R5: When `menable_ind` is 0, a non-M access to the supervisor or virtual-supervisor window gives an illegal-instruction exception. This holds in VS and VU as well, and it overrides any virtual-instruction outcome.
- R6: In M mode, `menable_ind`, `henable_ind` and `virt_mode` have no effect.
- R7: When `menable_ind` is 1, a VS or VU access to the virtual-supervisor window gives a virtual-instruction exception.
- R8: A VU access to the supervisor window gives a virtual-instruction exception. A non-virtualized U access to the supervisor or virtual-supervisor window gives an illegal-instruction exception.
- R9: When `menable_ind` is 1 and `henable_ind` is 0, a VS access to the supervisor window gives a virtual-instruction exception. This applies to the select register and to the aliases, whatever the implemented flags are.
- R10: A VS alias access to the supervisor window with `sel_impl_host`=1 and `sel_impl_guest`=0 gives a virtual-instruction exception. A select-register access in the same state is granted.
- R11: An alias access that passes every earlier check but has `sel_impl_host`=0 gives an illegal-instruction exception. A select-register access never depends on the implemented flags.
- R12: Privilege encoding: 2'b11 is M, 2'b01 is S, and 2'b00 or 2'b10 is U. S or U with `virt_mode`=1 is VS or VU. An HS access to the supervisor or virtual-supervisor window that passes all checks is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address of the access |
| priv_lvl | input | 2 | Current privilege level (11 M, 01 S, 00/10 U) |
| virt_mode | input | 1 | Virtualization bit |
| menable_ind | input | 1 | Machine state-enable gate for the indirect windows |
| henable_ind | input | 1 | Hypervisor state-enable gate for the indirect windows |
| sel_impl_host | input | 1 | Current select value is implemented for the host |
| sel_impl_guest | input | 1 | Current select value is implemented for the guest |
| acc_grant | output | 1 | Access permitted |
| exc_illegal | output | 1 | Illegal-instruction exception |
| exc_virtual | output | 1 | Virtual-instruction exception |

## Verification
The assertions assume that the three window bases are distinct and aligned to the window span, which holds for the default parameters. They also assume that the inputs are stable around each rising edge, because each property relates one cycle's inputs to the next cycle's outputs. The stimulus keeps to these assumptions by using the default bases and by changing inputs only on falling edges. It also holds reset during the first cycles, so no property sees undriven outputs. Every privilege encoding is driven, including the spare value 2'b10.

// File: rtl/ind_csr_pkg.sv
package ind_csr_pkg;

  typedef enum logic [1:0] {
    WIN_NONE,
    WIN_MACH,
    WIN_SUP,
    WIN_VSUP
  } win_e;

  typedef enum logic [2:0] {
    MODE_M,
    MODE_HS,
    MODE_U,
    MODE_VS,
    MODE_VU
  } mode_e;

  typedef enum logic [1:0] {
    VERD_NONE,
    VERD_GRANT,
    VERD_ILLEGAL,
    VERD_VIRTUAL
  } verd_e;

  localparam logic [1:0] PRIV_M = 2'b11;
  localparam logic [1:0] PRIV_S = 2'b01;

endpackage

// File: rtl/ind_csr_win_decode.sv
module ind_csr_win_decode
  import ind_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MACH_BASE = 12'h350,
  parameter logic [ADDR_W-1:0] SUP_BASE  = 12'h150,
  parameter logic [ADDR_W-1:0] VSUP_BASE = 12'h250,
  parameter int WIN_SPAN = 8,
  parameter int GAP_OFS  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic              is_sel
);
  localparam int OFS_W = $clog2(WIN_SPAN);
  localparam int NWIN  = 3;
  localparam logic [ADDR_W-1:0] WIN_BASE [NWIN] = '{MACH_BASE, SUP_BASE, VSUP_BASE};

  logic [NWIN-1:0] hit;
  logic            gap;

  assign gap = (addr[OFS_W-1:0] == OFS_W'(GAP_OFS));

  // one comparator per window, upper address bits against the aligned base
  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign hit[g] = (addr[ADDR_W-1:OFS_W] == WIN_BASE[g][ADDR_W-1:OFS_W]) && !gap;
  end

  always_comb begin
    if (hit[0])      win = WIN_MACH;
    else if (hit[1]) win = WIN_SUP;
    else if (hit[2]) win = WIN_VSUP;
    else             win = WIN_NONE;
  end

  assign is_sel = (addr[OFS_W-1:0] == '0);

endmodule

// File: rtl/ind_csr_mode.sv
module ind_csr_mode
  import ind_csr_pkg::*;
(
  input  logic [1:0] priv_lvl,
  input  logic       virt_mode,
  output mode_e      mode
);
  always_comb begin
    if (priv_lvl == PRIV_M)      mode = MODE_M;
    else if (priv_lvl == PRIV_S) mode = virt_mode ? MODE_VS : MODE_HS;
    else                         mode = virt_mode ? MODE_VU : MODE_U;
  end
endmodule

// File: rtl/ind_csr_verdict.sv
module ind_csr_verdict
  import ind_csr_pkg::*;
(
  input  win_e  win,
  input  logic  is_sel,
  input  mode_e mode,
  input  logic  men,
  input  logic  hen,
  input  logic  impl_host,
  input  logic  impl_guest,
  output verd_e verd
);
  logic below_m, virt_lvl, sv_win;
  logic tier_priv, tier_virt, tier_unimpl;

  assign below_m  = (mode != MODE_M);
  assign virt_lvl = (mode == MODE_VS) || (mode == MODE_VU);
  assign sv_win   = (win == WIN_SUP) || (win == WIN_VSUP);

  // tier 1: privilege level and machine gate
  assign tier_priv = ((win == WIN_MACH) && below_m)
                   || (sv_win && below_m && !men)
                   || (sv_win && (mode == MODE_U));

  // tier 2: virtualization faults
  assign tier_virt = ((win == WIN_VSUP) && virt_lvl)
                   || ((win == WIN_SUP) && (mode == MODE_VU))
                   || ((win == WIN_SUP) && (mode == MODE_VS) && !hen)
                   || ((win == WIN_SUP) && (mode == MODE_VS) && !is_sel
                       && impl_host && !impl_guest);

  // tier 3: alias with unimplemented select value
  assign tier_unimpl = !is_sel && !impl_host;

  always_comb begin
    if (win == WIN_NONE) verd = VERD_NONE;
    else if (tier_priv)  verd = VERD_ILLEGAL;
    else if (tier_virt)  verd = VERD_VIRTUAL;
    else if (tier_unimpl) verd = VERD_ILLEGAL;
    else                 verd = VERD_GRANT;
  end
endmodule

// File: rtl/ind_csr_guard.sv
module ind_csr_guard
  import ind_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MACH_BASE = 12'h350,
  parameter logic [ADDR_W-1:0] SUP_BASE  = 12'h150,
  parameter logic [ADDR_W-1:0] VSUP_BASE = 12'h250,
  parameter int WIN_SPAN = 8,
  parameter int GAP_OFS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [1:0]        priv_lvl,
  input  logic              virt_mode,
  input  logic              menable_ind,
  input  logic              henable_ind,
  input  logic              sel_impl_host,
  input  logic              sel_impl_guest,
  output logic              acc_grant,
  output logic              exc_illegal,
  output logic              exc_virtual
);
  win_e  win;
  logic  is_sel;
  mode_e mode;
  verd_e verd;

  ind_csr_win_decode #(
    .ADDR_W(ADDR_W), .MACH_BASE(MACH_BASE), .SUP_BASE(SUP_BASE),
    .VSUP_BASE(VSUP_BASE), .WIN_SPAN(WIN_SPAN), .GAP_OFS(GAP_OFS)
  ) u_dec (
    .addr(csr_addr), .win(win), .is_sel(is_sel)
  );

  ind_csr_mode u_mode (
    .priv_lvl(priv_lvl), .virt_mode(virt_mode), .mode(mode)
  );

  ind_csr_verdict u_verd (
    .win(win), .is_sel(is_sel), .mode(mode), .men(menable_ind),
    .hen(henable_ind), .impl_host(sel_impl_host),
    .impl_guest(sel_impl_guest), .verd(verd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_grant   <= 1'b0;
      exc_illegal <= 1'b0;
      exc_virtual <= 1'b0;
    end else begin
      acc_grant   <= (verd == VERD_GRANT);
      exc_illegal <= (verd == VERD_ILLEGAL);
      exc_virtual <= (verd == VERD_VIRTUAL);
    end
  end

  // R3
  out_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_grant, exc_illegal, exc_virtual}));

  // R2
  outside_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (win == WIN_NONE) |=> !(acc_grant || exc_illegal || exc_virtual));

  // R5
  mgate_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    ((win == WIN_SUP || win == WIN_VSUP) && priv_lvl != PRIV_M && !menable_ind)
    |=> exc_illegal);

  // R6
  mmode_free_chk: assert property (@(posedge clk) disable iff (rst)
    (win != WIN_NONE && priv_lvl == PRIV_M && (is_sel || sel_impl_host))
    |=> acc_grant);

  // R7
  vsup_virtual_chk: assert property (@(posedge clk) disable iff (rst)
    (win == WIN_VSUP && virt_mode && priv_lvl != PRIV_M && menable_ind)
    |=> exc_virtual);

  // R4
  mach_only_chk: assert property (@(posedge clk) disable iff (rst)
    (win == WIN_MACH && priv_lvl != PRIV_M) |=> exc_illegal);

endmodule

// File: tb/tb_ind_csr_guard.sv
module tb_ind_csr_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] csr_addr = '0;
  logic [1:0]  priv_lvl = 2'b11;
  logic        virt_mode = 1'b0;
  logic        menable_ind = 1'b1;
  logic        henable_ind = 1'b1;
  logic        sel_impl_host = 1'b1;
  logic        sel_impl_guest = 1'b1;
  logic        acc_grant, exc_illegal, exc_virtual;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // verdict codes used by the bench
  localparam int NONE = 0, GRANT = 1, ILL = 2, VIRT = 3, MULTI = 7;
  localparam logic [1:0] PM = 2'b11, PS = 2'b01, PU = 2'b00, PX = 2'b10;

  always #5 clk = ~clk;

  ind_csr_guard dut (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .priv_lvl(priv_lvl),
    .virt_mode(virt_mode), .menable_ind(menable_ind),
    .henable_ind(henable_ind), .sel_impl_host(sel_impl_host),
    .sel_impl_guest(sel_impl_guest), .acc_grant(acc_grant),
    .exc_illegal(exc_illegal), .exc_virtual(exc_virtual)
  );

  function automatic int observed();
    int c;
    c = int'(acc_grant) + int'(exc_illegal) + int'(exc_virtual);
    if (c > 1)       return MULTI;
    if (acc_grant)   return GRANT;
    if (exc_illegal) return ILL;
    if (exc_virtual) return VIRT;
    return NONE;
  endfunction

  task automatic check(input string req, input int exp);
    int got;
    got = observed();
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got verdict %0d expected %0d (addr=%h)", req, got, exp, csr_addr);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge (one register)
  task automatic run(input logic [11:0] a, input logic [1:0] p, input logic v,
                     input logic me, input logic he, input logic ih, input logic ig,
                     input int exp, input string req);
    @(negedge clk);
    csr_addr = a; priv_lvl = p; virt_mode = v; menable_ind = me;
    henable_ind = he; sel_impl_host = ih; sel_impl_guest = ig;
    @(negedge clk);
    check(req, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    csr_addr = 12'h351; priv_lvl = PM;
    @(negedge clk);
    check("R1 reset", NONE);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", GRANT);
  endtask

  task automatic t_outside();
    run(12'h354, PM, 0, 1, 1, 1, 1, NONE, "R2 machine gap");
    run(12'h154, PS, 0, 1, 1, 1, 1, NONE, "R2 sup gap");
    run(12'h358, PM, 0, 1, 1, 1, 1, NONE, "R2 past end");
    run(12'h34F, PM, 0, 1, 1, 1, 1, NONE, "R2 before base");
    run(12'h000, PU, 1, 0, 0, 0, 0, NONE, "R2 unrelated");
    run(12'h257, PS, 0, 1, 1, 1, 1, GRANT, "R2 last offset");
  endtask

  task automatic t_machine();
    run(12'h350, PM, 0, 1, 1, 1, 1, GRANT, "R4 M select");
    run(12'h357, PM, 1, 0, 0, 1, 0, GRANT, "R6 M alias gates off virt set");
    run(12'h351, PS, 0, 1, 1, 1, 1, ILL, "R4 HS to machine");
    run(12'h350, PS, 1, 1, 1, 1, 1, ILL, "R4 VS to machine");
    run(12'h353, PX, 0, 1, 1, 1, 1, ILL, "R4 spare-U to machine");
    run(12'h352, PM, 0, 1, 1, 0, 0, ILL, "R11 M alias unimpl");
    run(12'h350, PM, 0, 1, 1, 0, 0, GRANT, "R11 M select unimpl");
  endtask

  task automatic t_mgate();
    run(12'h150, PS, 0, 0, 1, 1, 1, ILL, "R5 HS sup");
    run(12'h251, PU, 0, 0, 1, 1, 1, ILL, "R5 U vsup");
    run(12'h151, PS, 1, 0, 0, 1, 1, ILL, "R5 VS over virtual");
    run(12'h250, PU, 1, 0, 1, 1, 1, ILL, "R5 VU vsup");
    run(12'h151, PM, 0, 0, 0, 1, 1, GRANT, "R6 M sup gates off");
    run(12'h256, PM, 1, 0, 0, 1, 0, GRANT, "R6 M vsup gates off");
  endtask

  task automatic t_vsup();
    run(12'h250, PS, 1, 1, 1, 1, 1, VIRT, "R7 VS vsup select");
    run(12'h257, PU, 1, 1, 1, 1, 1, VIRT, "R7 VU vsup alias");
    run(12'h252, PS, 1, 1, 1, 0, 0, VIRT, "R7 VS vsup beats unimpl");
    run(12'h252, PS, 0, 1, 0, 1, 1, GRANT, "R12 HS vsup");
    run(12'h250, PU, 0, 1, 1, 1, 1, ILL, "R8 U vsup");
  endtask

  task automatic t_sup();
    run(12'h151, PU, 1, 1, 1, 1, 1, VIRT, "R8 VU sup");
    run(12'h151, PU, 0, 1, 1, 1, 1, ILL, "R8 U sup");
    run(12'h150, PX, 0, 1, 1, 1, 1, ILL, "R8 spare-U sup");
    run(12'h150, PS, 1, 1, 0, 1, 1, VIRT, "R9 VS sup select hgate off");
    run(12'h153, PS, 1, 1, 0, 0, 0, VIRT, "R9 VS sup alias hgate off");
    run(12'h151, PS, 1, 1, 1, 1, 0, VIRT, "R10 VS alias host-only");
    run(12'h150, PS, 1, 1, 1, 1, 0, GRANT, "R10 VS select host-only");
    run(12'h155, PS, 1, 1, 1, 0, 0, ILL, "R11 VS alias unimpl");
    run(12'h151, PS, 1, 1, 1, 1, 1, GRANT, "R12 VS alias impl");
    run(12'h156, PS, 0, 1, 1, 0, 1, ILL, "R11 HS alias unimpl");
    run(12'h156, PS, 0, 1, 0, 1, 0, GRANT, "R12 HS alias impl");
    run(12'h150, PS, 0, 1, 1, 0, 0, GRANT, "R11 HS select unimpl");
  endtask

  task automatic t_exclusive();
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        csr_addr = 12'h151; priv_lvl = 2'(p); virt_mode = k[0];
        menable_ind = k[1]; henable_ind = k[2];
        sel_impl_host = k[0]; sel_impl_guest = 1'b0;
        @(negedge clk);
        n_checks++;
        if (!(observed() inside {GRANT, ILL, VIRT})) begin
          n_fail++;
          $display("FAIL R3 exclusive: got verdict %0d expected one of 1..3", observed());
        end
      end
    end
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    csr_addr = 12'h351; priv_lvl = PM; virt_mode = 0; menable_ind = 1;
    henable_ind = 1; sel_impl_host = 1; sel_impl_guest = 1;
    @(negedge clk);
    check("R1 stream first", GRANT);
    csr_addr = 12'h251; priv_lvl = PS; virt_mode = 1;
    @(negedge clk);
    check("R1 stream second", VIRT);
    csr_addr = 12'h354;
    @(negedge clk);
    check("R1 stream third", NONE);
    rst = 1'b1; csr_addr = 12'h351; priv_lvl = PM;
    @(negedge clk);
    check("R1 mid reset", NONE);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_outside();
    t_machine();
    t_mgate();
    t_vsup();
    t_sup();
    t_exclusive();
    t_back_to_back();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule